// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block produces the blanking flag for the output path of an interlaced video decoder. The flag tells active picture samples apart from the horizontal and vertical blanking intervals. A pixel counter runs on a pixel-rate clock enable. It returns to zero when a horizontal sync marker comes out of a fixed pipeline delay. A line counter restarts whenever the field identifier changes at a line boundary. The flag is formed by comparing both counters with programmable window limits.

Horizontal blanking is a set/clear window driven by equality compares. The start point normally sits in the front porch of the previous line, so the window spans the counter reset. Both compares ignore the least significant count bit, which gives two-pixel resolution. Vertical blanking works on whole lines only. A line is marked inactive once, at its boundary, and an inactive line stays blanked from end to end. The window limits are loaded through a byte-wide write port into shadow copies. These copies become live at the next field start, so a field is never blanked with a mix of old and new limits. The same structure handles 525-line and 625-line interlaced sequencing, since only the register values differ. The current pixel and line counts are brought out for debug.

Top module: `blank_gen`

## Requirements
- R1: After reset the blanking output is 1, both counts are 0, and the live and shadow limits hold the parameter defaults.
- R2: On an enabled cycle the pixel count becomes 0 if the sync marker sampled SYNC_DLY enabled cycles earlier arrives in that cycle. Otherwise it increments by one, and it holds once it reaches all ones.
- R3: On an active line, blanking sets when count[top:1] equals start[9:1]. It clears when count[top:1] equals the end byte. Start is 10 bits: address 0 holds bits 7:0 and address 1 bits 1:0 hold bits 9:8. The end byte is at address 2 and marks pixel 2×value. The window may span the counter reset.
- R4: Bit 0 of the horizontal start value has no effect, so an odd start behaves like the even value below it.
- R5: The line count becomes 1 on the delayed marker where field_id differs from the value taken at the previous line boundary. Every other delayed marker adds one. A line is inactive when its number is at least the vertical start (address 3 = bits 7:0, address 4 bits 1:0 = bits 9:8) or below the vertical end byte (address 5). An inactive line is blanked for its whole length.
- R6: The inactive-line decision changes only at a delayed sync marker. The horizontal window never unblanks any part of an inactive line.
- R7: Register writes land in shadow copies. They take effect at the next field start and do not change blanking within the current field.
- R8: While the pixel enable is low, the counts and blanking do not change, and the sync marker and field identifier are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-rate clock enable |
| sync_mark | input | 1 | Horizontal sync-tip marker, qualified by pix_ce |
| field_id | input | 1 | Field identifier |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| blank | output | 1 | Blanking flag |
| pix_count | output | PIX_W | Current pixel count |
| line_count | output | LINE_W | Current line number within the field |

## Verification
The bench builds the block with PIX_W = 11 and SYNC_DLY = 2, and uses 40-pixel lines and 12-line fields. These settings make the following reachable in a few thousand cycles: four full fields, a horizontal window that wraps across the counter reset, whole-line vertical blanking at both ends of a field, and shadow loading at each field change. The wider counter tests the zero-extended compare against the 10-bit start value. The two-stage marker delay shows that the counter resets on the delayed marker and not on the raw one.

// File: rtl/blank_gen_pkg.sv
package blank_gen_pkg;
   localparam int HS_W = 10;
   localparam int HE_W = 8;
   localparam int VS_W = 10;
   localparam int VE_W = 8;

   localparam logic [2:0] RA_HS_LO = 3'd0;
   localparam logic [2:0] RA_HS_HI = 3'd1;
   localparam logic [2:0] RA_HE    = 3'd2;
   localparam logic [2:0] RA_VS_LO = 3'd3;
   localparam logic [2:0] RA_VS_HI = 3'd4;
   localparam logic [2:0] RA_VE    = 3'd5;

   typedef struct packed {
      logic [HS_W-1:0] hs;
      logic [HE_W-1:0] he;
      logic [VS_W-1:0] vs;
      logic [VE_W-1:0] ve;
   } blank_cfg_t;
endpackage

// File: rtl/blank_regs.sv
module blank_regs
   import blank_gen_pkg::*;
#(
   parameter blank_cfg_t RST_CFG = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       load,
   output blank_cfg_t shadow,
   output blank_cfg_t active
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= RST_CFG;
      end else if (wr_en) begin
         case (wr_addr)
            RA_HS_LO: shadow.hs[7:0] <= wr_data;
            RA_HS_HI: shadow.hs[9:8] <= wr_data[1:0];
            RA_HE:    shadow.he      <= wr_data;
            RA_VS_LO: shadow.vs[7:0] <= wr_data;
            RA_VS_HI: shadow.vs[9:8] <= wr_data[1:0];
            RA_VE:    shadow.ve      <= wr_data;
            default:  ;
         endcase
      end
   end

   // live copy only moves at a field boundary
   always_ff @(posedge clk) begin
      if (!rst_n)    active <= RST_CFG;
      else if (load) active <= shadow;
   end
endmodule

// File: rtl/blank_hcount.sv
module blank_hcount #(
   parameter int PIX_W    = 11,
   parameter int SYNC_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             sync_in,
   input  logic [9:0]       hs,
   input  logic [7:0]       he,
   output logic             tip_dly,
   output logic [PIX_W-1:0] pix_cnt,
   output logic             h_blank
);
   localparam int CW = PIX_W - 1;
   localparam logic [PIX_W-1:0] PMAX = '1;

   logic hold_q;
   logic s_match, e_match;
   wire  unused_hs_lsb = hs[0];

   generate
      if (SYNC_DLY == 0) begin : g_nodly
         assign tip_dly = sync_in;
      end else begin : g_dly
         logic [SYNC_DLY-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n)  sr <= '0;
            else if (ce) sr <= (sr << 1) | SYNC_DLY'(sync_in);
         end
         assign tip_dly = sr[SYNC_DLY-1];
      end
   endgenerate

   // two-pixel resolution: bit 0 takes no part in either compare
   assign s_match = (pix_cnt[PIX_W-1:1] == CW'(hs[9:1]));
   assign e_match = (pix_cnt[PIX_W-1:1] == CW'(he));
   assign h_blank = s_match | (hold_q & ~e_match);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_cnt <= '0;
         hold_q  <= 1'b0;
      end else if (ce) begin
         hold_q <= h_blank;
         if (tip_dly)              pix_cnt <= '0;
         else if (pix_cnt != PMAX) pix_cnt <= pix_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/blank_vcount.sv
module blank_vcount #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              tip_dly,
   input  logic              field_in,
   input  logic [9:0]        vs_shd,
   input  logic [7:0]        ve_shd,
   input  logic [9:0]        vs_act,
   input  logic [7:0]        ve_act,
   output logic              field_start,
   output logic [LINE_W-1:0] line_cnt,
   output logic              v_inact
);
   localparam logic [LINE_W-1:0] LMAX = '1;

   logic              field_q;
   logic              bound;
   logic [LINE_W-1:0] nline;
   logic [9:0]        vs_eff;
   logic [7:0]        ve_eff;

   assign bound       = ce & tip_dly;
   assign field_start = bound & (field_in != field_q);
   assign vs_eff      = field_start ? vs_shd : vs_act;
   assign ve_eff      = field_start ? ve_shd : ve_act;

   always_comb begin
      if (field_start)          nline = LINE_W'(1);
      else if (line_cnt != LMAX) nline = line_cnt + 1'b1;
      else                      nline = line_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q  <= 1'b0;
         line_cnt <= '0;
         v_inact  <= 1'b1;
      end else if (bound) begin
         field_q  <= field_in;
         line_cnt <= nline;
         v_inact  <= (nline >= LINE_W'(vs_eff)) || (nline < LINE_W'(ve_eff));
      end
   end
endmodule

// File: rtl/blank_gen.sv
module blank_gen
   import blank_gen_pkg::*;
#(
   parameter int PIX_W    = 11,
   parameter int LINE_W   = 10,
   parameter int SYNC_DLY = 3,
   parameter int DEF_HS   = 850,
   parameter int DEF_HE   = 64,
   parameter int DEF_VS   = 262,
   parameter int DEF_VE   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_ce,
   input  logic              sync_mark,
   input  logic              field_id,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic              blank,
   output logic [PIX_W-1:0]  pix_count,
   output logic [LINE_W-1:0] line_count
);
   localparam blank_cfg_t RST_CFG = '{hs: HS_W'(DEF_HS), he: HE_W'(DEF_HE),
                                      vs: VS_W'(DEF_VS), ve: VE_W'(DEF_VE)};

   generate
      if (PIX_W < 10)   begin : g_bad_pw  $error("PIX_W must be at least 10"); end
      if (LINE_W < 10)  begin : g_bad_lw  $error("LINE_W must be at least 10"); end
      if (SYNC_DLY < 0) begin : g_bad_dly $error("SYNC_DLY must not be negative"); end
   endgenerate

   blank_cfg_t cfg_shd, cfg_act;
   logic       tip_dly, field_start, v_inact, h_blank;

   blank_regs #(.RST_CFG(RST_CFG)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .load(field_start), .shadow(cfg_shd), .active(cfg_act)
   );

   blank_hcount #(.PIX_W(PIX_W), .SYNC_DLY(SYNC_DLY)) hcnt_i (
      .clk(clk), .rst_n(rst_n), .ce(pix_ce), .sync_in(sync_mark),
      .hs(cfg_act.hs), .he(cfg_act.he), .tip_dly(tip_dly),
      .pix_cnt(pix_count), .h_blank(h_blank)
   );

   blank_vcount #(.LINE_W(LINE_W)) vcnt_i (
      .clk(clk), .rst_n(rst_n), .ce(pix_ce), .tip_dly(tip_dly), .field_in(field_id),
      .vs_shd(cfg_shd.vs), .ve_shd(cfg_shd.ve), .vs_act(cfg_act.vs), .ve_act(cfg_act.ve),
      .field_start(field_start), .line_cnt(line_count), .v_inact(v_inact)
   );

   assign blank = v_inact | h_blank;
endmodule

// File: rtl/blank_gen_chk.sv
module blank_gen_chk
   import blank_gen_pkg::*;
#(
   parameter int PIX_W  = 11,
   parameter int LINE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic              tip_dly,
   input logic              field_start,
   input logic              blank,
   input logic              v_inact,
   input logic [PIX_W-1:0]  pix_count,
   input logic [LINE_W-1:0] line_count,
   input blank_cfg_t        active
);
   // R2
   sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce && tip_dly |=> pix_count == '0);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce && !tip_dly && (pix_count != '1) |=> pix_count == $past(pix_count) + 1'b1);

   // R5
   field_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> line_count == LINE_W'(1));

   // R5
   inact_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_inact |-> blank);

   // R6
   line_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce && tip_dly) |=> $stable(v_inact));

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(active));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(pix_count) && $stable(line_count) && $stable(blank));
endmodule

bind blank_gen blank_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .ce(pix_ce), .tip_dly(tip_dly),
   .field_start(field_start), .blank(blank), .v_inact(v_inact),
   .pix_count(pix_count), .line_count(line_count), .active(cfg_act)
);

// File: tb/blank_gen_tb_top.sv
`timescale 1ns/1ps
module blank_gen_tb_top;
   localparam int PW = 11, LW = 10, D = 2, LINE_LEN = 40, FIELD_LINES = 12;
   localparam int DEF_HS = 850, DEF_HE = 64, DEF_VS = 262, DEF_VE = 20;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          pix_ce = 1'b0, sync_mark = 1'b0, field_id = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic          blank;
   logic [PW-1:0] pix_count;
   logic [LW-1:0] line_count;

   always #4 clk = ~clk;

   blank_gen #(.PIX_W(PW), .LINE_W(LW), .SYNC_DLY(D), .DEF_HS(DEF_HS),
               .DEF_HE(DEF_HE), .DEF_VS(DEF_VS), .DEF_VE(DEF_VE)) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .sync_mark(sync_mark),
      .field_id(field_id), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .blank(blank), .pix_count(pix_count), .line_count(line_count)
   );

   typedef struct {
      int    pix;
      int    line;
      bit    blk;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   int total = 0, bad = 0;
   string phase = "R3";

   // bench model state
   int m_pix = 0, m_line = 0;
   bit m_hold = 0, m_vin = 1, m_fq = 0;
   bit m_sr[D];
   int a_hs = DEF_HS, a_he = DEF_HE, a_vs = DEF_VS, a_ve = DEF_VE;
   int s_hs = DEF_HS, s_he = DEF_HE, s_vs = DEF_VS, s_ve = DEF_VE;

   function automatic bit hwin(int pix, bit hold, int hs, int he);
      return ((pix >> 1) == (hs >> 1)) || (hold && ((pix >> 1) != he));
   endfunction

   task automatic check(string req, int act, int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(addr); reg_wdata = 8'(data);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
      case (addr)
         0: s_hs = (s_hs & 'h300) | data;
         1: s_hs = (s_hs & 'hFF) | ((data & 3) << 8);
         2: s_he = data;
         3: s_vs = (s_vs & 'h300) | data;
         4: s_vs = (s_vs & 'hFF) | ((data & 3) << 8);
         5: s_ve = data;
         default: ;
      endcase
   endtask

   // driver: one enabled cycle followed by one idle cycle
   task automatic step(bit tip, bit fld);
      bit dly, fs, nhold;
      int nline;
      exp_t e;
      @(negedge clk);
      pix_ce = 1'b1; sync_mark = tip; field_id = fld;
      dly = m_sr[D-1];
      for (int i = D - 1; i > 0; i--) m_sr[i] = m_sr[i-1];
      m_sr[0] = tip;
      fs    = dly && (fld != m_fq);
      nhold = hwin(m_pix, m_hold, a_hs, a_he);
      if (dly) m_pix = 0;
      else if (m_pix != (1 << PW) - 1) m_pix++;
      nline = fs ? 1 : (dly && m_line != (1 << LW) - 1) ? m_line + 1 : m_line;
      if (fs) begin
         m_fq = fld; a_hs = s_hs; a_he = s_he; a_vs = s_vs; a_ve = s_ve;
      end
      if (dly) begin
         m_line = nline;
         m_vin  = (nline >= a_vs) || (nline < a_ve);
      end
      m_hold = nhold;
      e.pix  = m_pix;
      e.line = m_line;
      e.blk  = m_vin || hwin(m_pix, m_hold, a_hs, a_he);
      if (m_vin) e.tag = hwin(m_pix, m_hold, a_hs, a_he) ? "R5" : "R6";
      else       e.tag = phase;
      exp_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      pix_ce = 1'b0; sync_mark = 1'b0;
   endtask

   // monitor: compares each enabled-edge result
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check("R2", int'(pix_count), e.pix);
         check("R5", int'(line_count), e.line);
         check(e.tag, int'(blank), int'(e.blk));
      end
   end

   task automatic run_field(bit fld, int wr_line, int wr_val, string after_tag);
      for (int l = 0; l < FIELD_LINES; l++) begin
         if (l == wr_line) begin
            wr(0, wr_val);
            phase = after_tag;
         end
         for (int p = 0; p < LINE_LEN; p++) step(p == 0, fld);
      end
   endtask

   initial begin
      #(8 * 100000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int p0, l0, b0;
      for (int i = 0; i < D; i++) m_sr[i] = 0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1", int'(blank), 1);
      check("R1", int'(pix_count), 0);
      check("R1", int'(line_count), 0);

      // start 36 wraps across the line reset (40 px); end byte 4 -> pixel 8
      wr(0, 36); wr(1, 0); wr(2, 4);
      // lines 1..2 and 10..12 of each field inactive
      wr(3, 10); wr(4, 0); wr(5, 3);

      phase = "R3";
      run_field(1'b1, 5, 20, "R7");   // R7: mid-field write must wait for next field
      run_field(1'b0, 5, 21, "R7");   // new start 20 live; odd 21 staged
      phase = "R4";
      run_field(1'b1, -1, 0, "R4");   // R4: 21 must act like 20
      phase = "R3";
      for (int l = 0; l < 5; l++)
         for (int p = 0; p < LINE_LEN; p++) step(p == 0, 1'b0);

      // R8: enable low while marker and field toggle
      @(negedge clk);
      p0 = int'(pix_count); l0 = int'(line_count); b0 = int'(blank);
      sync_mark = 1'b1; field_id = 1'b1;
      repeat (5) @(negedge clk);
      check("R8", int'(pix_count), p0);
      check("R8", int'(line_count), l0);
      check("R8", int'(blank), b0);
      sync_mark = 1'b0; field_id = 1'b0;

      for (int l = 5; l < FIELD_LINES; l++)
         for (int p = 0; p < LINE_LEN; p++) step(p == 0, 1'b0);

      repeat (4) @(posedge clk);
      #3;
      check("R2", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule